// File: doc/BRIEF.md
# Iterative 32-bit Integer Divider

This block is the multi-cycle divide unit of a 32-bit integer core. It serves both the unsigned and the signed divide instructions. The pipeline raises `start` for one cycle with the two operands and a mode select. The divider then raises `busy`, produces one quotient bit per cycle using restoring division on the operand magnitudes, and finally presents the quotient together with a single-cycle `done` pulse. The remainder is not exported. Destination-register handling belongs to the surrounding pipeline.

The unit never raises an exception. A zero divisor, and in signed mode the most-negative dividend divided by minus one, are both handled by using a divisor of one in place of the real divisor. In those cases the quotient is simply the dividend. The signed quotient rounds toward zero.

Top module: `int_divider`

## Requirements
- R1: While `rst` is high at a rising clock edge, `busy` and `done` are cleared and `quotient` is set to zero.
- R2: A `start` sampled while `busy` is low makes `busy` high after that edge. `done` rises exactly 32 clock edges after the accepting edge, and `busy` falls on the same edge.
- R3: `done` is high for exactly one cycle per accepted operation.
- R4: With `isSigned` = 0 (the unsigned divide, extended opcode 36), both operands are read as 32-bit unsigned values. The quotient is the floor of dividend divided by divisor.
- R5: With `isSigned` = 1 (the signed divide, extended opcode 37), both operands are read as two's-complement values. The quotient is truncated toward zero, so it is negative exactly when the operand signs differ.
- R6: In unsigned mode, a divisor of 0 yields a quotient equal to the dividend.
- R7: In signed mode, a divisor of 0 yields a quotient equal to the dividend.
- R8: In signed mode, a dividend of 0x80000000 with a divisor of 0xFFFFFFFF yields 0x80000000.
- R9: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands and its timing, and no second operation follows it.
- R10: `quotient` changes only on the edge that raises `done`. It holds its value at all other times, including throughout the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| isSigned | input | 1 | 1 = signed divide, 0 = unsigned divide |
| dividend | input | 32 | Dividend, sampled with an accepted start |
| divisor | input | 32 | Divisor, sampled with an accepted start |
| busy | output | 1 | High while the iteration runs |
| done | output | 1 | One-cycle pulse when the quotient is valid |
| quotient | output | 32 | Result of the latest completed division |

## Verification
The bench builds the divider with its default width of 32. At that width, the real instruction corner cases can be reached exactly: 0x80000000 divided by 0xFFFFFFFF in both modes, the all-ones dividend, and zero divisors of either sign of dividend. The 32-edge latency also becomes a concrete count that the bench can check against its own cycle model. A second start issued mid-run checks that the ignored request leaves both the result and the timing untouched.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture prepared operands
    logic step;   // perform one restoring iteration
    logic last;   // current step is the final one; latch result
  } divStrobe_t;
endpackage

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strobe.load = start & ~busyQ;
    strobe.step = busyQ;
    strobe.last = busyQ & (iterCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      iterCnt <= '0;
    end else begin
      doneQ <= strobe.last;
      if (strobe.load) begin
        busyQ   <= 1'b1;
        iterCnt <= '0;
      end else if (strobe.step) begin
        iterCnt <= iterCnt + 1'b1;
        if (strobe.last) busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/div_datapath.sv
`timescale 1ns/1ps
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobe_t       strobe,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  // Operand preparation
  logic             divByZero, signedOvf, aNeg, bNeg;
  logic [WIDTH-1:0] effDivisor, aMag, bMag;

  always_comb begin
    divByZero  = (divisor == '0);
    signedOvf  = isSigned & (dividend == MOST_NEG) & (divisor == ALL_ONES);
    effDivisor = (divByZero | signedOvf) ? ONE : divisor;
    aNeg       = isSigned & dividend[WIDTH-1];
    bNeg       = isSigned & effDivisor[WIDTH-1];
    aMag       = aNeg ? (~dividend + ONE) : dividend;
    bMag       = bNeg ? (~effDivisor + ONE) : effDivisor;
  end

  // Iteration state
  logic [WIDTH:0]   remQ;
  logic [WIDTH-1:0] quoQ, dvsQ, resultQ;
  logic             negQ;

  logic [WIDTH:0]   shifted, trial, remNext;
  logic [WIDTH-1:0] quoNext, finalQ;
  logic             fits;

  always_comb begin
    shifted = {remQ[WIDTH-1:0], quoQ[WIDTH-1]};
    trial   = shifted - {1'b0, dvsQ};
    fits    = ~trial[WIDTH];
    remNext = fits ? trial : shifted;
    quoNext = {quoQ[WIDTH-2:0], fits};
    finalQ  = negQ ? (~quoNext + ONE) : quoNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remQ    <= '0;
      quoQ    <= '0;
      dvsQ    <= '0;
      negQ    <= 1'b0;
      resultQ <= '0;
    end else if (strobe.load) begin
      remQ <= '0;
      quoQ <= aMag;
      dvsQ <= bMag;
      negQ <= aNeg ^ bNeg;
    end else if (strobe.step) begin
      remQ <= remNext;
      quoQ <= quoNext;
      if (strobe.last) resultQ <= finalQ;
    end
  end

  assign quotient = resultQ;
endmodule

// File: rtl/int_divider.sv
`timescale 1ns/1ps
module int_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient
);
  divStrobe_t strobe;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .quotient(quotient)
  );
endmodule

// File: rtl/int_divider_chk.sv
`timescale 1ns/1ps
module int_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient
);
  localparam int WW = $clog2(WIDTH) + 2;
  logic [WW-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (rst) winCnt <= '0;
    else     winCnt <= busy ? winCnt + 1'b1 : '0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!busy && !done && quotient == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (winCnt == WW'(WIDTH)));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy && !done) |=> busy);

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> (busy || done));

  // R10
  quotient_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> (quotient == $past(quotient)));
endmodule

bind int_divider int_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .quotient(quotient)
);

// File: tb/sim_int_divider.sv
`timescale 1ns/1ps
module sim_int_divider;
  localparam int W = 32;

  logic         clk = 1'b0, rst = 1'b1, start = 1'b0, isSigned = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient;

  int    total = 0, bad = 0;
  bit    finished = 0, compareOn = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  int_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  function automatic logic [31:0] refDiv(logic [31:0] a, logic [31:0] b, bit s);
    longint sa, sb, q;
    if (b == 0) return a;
    if (!s) return 32'(longint'({32'd0, a}) / longint'({32'd0, b}));
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (sa == -64'sd2147483648 && sb == -1) return a;
    q = sa / sb;
    return q[31:0];
  endfunction

  // Behavioural cycle model
  bit          mBusy = 0, mDone = 0;
  logic [31:0] mQ = '0, pend = '0;
  int          mCnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mDone = 0; mQ = '0; mCnt = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == W) begin mBusy = 0; mDone = 1; mQ = pend; end
      end else if (start) begin
        mBusy = 1; mCnt = 0; pend = refDiv(dividend, divisor, isSigned);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn && !rst) begin
      chk(busy == mBusy, "R2", "busy vs model", 32'(busy), 32'(mBusy));
      chk(done == mDone, "R3", "done vs model", 32'(done), 32'(mDone));
      chk(quotient == mQ, curReq, "quotient vs model", quotient, mQ);
    end
  end

  task automatic runDiv(logic [31:0] a, logic [31:0] b, bit s, string req, bit intrude);
    logic [31:0] exp;
    int lat;
    exp = refDiv(a, b, s);
    curReq = req;
    @(negedge clk);
    dividend = a; divisor = b; isSigned = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (intrude && lat == 5) begin
        // R9: second request with different operands while running
        dividend = 32'd1000; divisor = 32'd10; isSigned = 1'b0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == W + 1, "R2", "latency in negedges", 32'(lat), 32'(W + 1));
    chk(quotient == exp, req, "quotient", quotient, exp);
    @(negedge clk);
    chk(!done, "R3", "done one cycle only", 32'(done), 32'd0);
    if (intrude) chk(!busy, "R9", "no second run after ignored start", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy in reset", 32'(busy), 32'd0);
    chk(!done, "R1", "done in reset", 32'(done), 32'd0);
    chk(quotient == '0, "R1", "quotient in reset", quotient, 32'd0);
    rst = 1'b0;
    compareOn = 1;

    // R4 unsigned
    runDiv(32'd100, 32'd7, 1'b0, "R4", 1'b0);
    runDiv(32'hFFFF_FFFF, 32'd3, 1'b0, "R4", 1'b0);
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R4", 1'b0);
    runDiv(32'd5, 32'd9, 1'b0, "R4", 1'b0);
    // R6 unsigned zero divisor
    runDiv(32'hDEAD_BEEF, 32'd0, 1'b0, "R6", 1'b0);
    // R5 signed, truncation toward zero
    runDiv(32'hFFFF_FFF9, 32'd2, 1'b1, "R5", 1'b0);
    runDiv(32'd7, 32'hFFFF_FFFE, 1'b1, "R5", 1'b0);
    runDiv(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, "R5", 1'b0);
    runDiv(32'h8000_0000, 32'd2, 1'b1, "R5", 1'b0);
    chk(quotient == 32'hC000_0000, "R5", "most-negative halved", quotient, 32'hC000_0000);
    // R7 signed zero divisor
    runDiv(32'hFFFF_FFF7, 32'd0, 1'b1, "R7", 1'b0);
    // R8 signed overflow case
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8", 1'b0);
    chk(quotient == 32'h8000_0000, "R8", "overflow quotient", quotient, 32'h8000_0000);
    // R9 start while busy ignored
    runDiv(32'd1234567, 32'd89, 1'b0, "R9", 1'b1);
    // R10 hold after completion
    begin
      logic [31:0] held;
      held = quotient;
      curReq = "R10";
      repeat (10) @(negedge clk);
      chk(quotient == held, "R10", "quotient held while idle", quotient, held);
    end
    runDiv(32'd50, 32'd5, 1'b0, "R10", 1'b0);

    compareOn = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule